// File: doc/BRIEF.md
# Power Fault Response Sequencer

This block decides how a multi-rail power controller reacts when its analog comparators flag trouble. Every rail reports three flags: a cycle-limit overcurrent, a hard overcurrent and an undervoltage. The die reports a temperature warning and a thermal shutdown. From these flags the block drives one global rail-enable, a live status vector, a sticky status vector cleared by write-one-to-clear, and an active-low interrupt line.

A shutdown turns the rails off and then waits. The wait is counted in ticks of a 1 kHz time base. An undervoltage or thermal shutdown waits the long delay (100 ticks by default). A hard overcurrent waits the short delay (14 ticks by default). When the wait ends, the block raises a single restart request. Mask bits use the same positions as the status bits. A mask bit keeps its condition off the interrupt line. Two mask bits do more than that: the undervoltage mask and the thermal-shutdown mask also stop those conditions from shutting the rails down. A hard overcurrent always shuts the rails down, whatever its mask says.

Top module: `pwr_fault_seq`

## Requirements
- R1: An undervoltage on any rail, with mask bit 2 clear, drives rails_en low on the next clock. After that, UV_DLY ticks must be counted while no fault input is asserted. On the clock of the last tick, restart_req pulses high for exactly one cycle and rails_en returns high. With mask bit 2 set, an undervoltage leaves rails_en high.
- R2: A hard overcurrent on any rail drives rails_en low on the next clock. The block then restarts after OC_DLY fault-free ticks.
- R3: Mask bit 1 does not stop a hard-overcurrent shutdown. It only keeps that condition off irq_n.
- R4: While the rails are off, any active shutdown cause holds the remaining delay at the larger of the remaining count and the cause's own delay, and no tick is consumed. So a short event cannot shorten a long wait, and a long event extends a short wait.
- R5: A thermal shutdown, with mask bit 4 clear, turns the rails off. The restart comes UV_DLY ticks after the flag clears. With mask bit 4 set, the rails stay on.
- R6: A temperature warning pulls irq_n low unless mask bit 3 is set. It never turns the rails off.
- R7: A cycle-limit overcurrent on its own does not turn the rails off.
- R8: live_stat follows the inputs in the same cycle, whatever the masks are. Bit 0 is the OR of the cycle-limit flags, bit 1 the OR of the hard-overcurrent flags, bit 2 the OR of the undervoltage flags, bit 3 the temperature warning and bit 4 the thermal shutdown.
- R9: latched_stat sets a bit one clock after the live bit is seen. The bit stays set until a clr_stb cycle writes a one to that position in clr_bits. If the condition is still live on that cycle, the bit stays set.
- R10: irq_n is low exactly when some bit of latched_stat is set and its irq_mask bit is clear.
- R11: After reset, rails_en is high, restart_req is low, latched_stat is zero and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the 1 kHz time base |
| cyc_lim_oc | input | N_RAILS | Per-rail cycle-limit overcurrent flags |
| hard_oc | input | N_RAILS | Per-rail hard overcurrent flags |
| uv | input | N_RAILS | Per-rail undervoltage flags |
| temp_warn | input | 1 | Die temperature warning |
| temp_shut | input | 1 | Die thermal shutdown |
| irq_mask | input | 5 | Mask bits, same positions as the status bits |
| clr_stb | input | 1 | Write strobe that clears latched status bits |
| clr_bits | input | 5 | Write-one-to-clear pattern used with clr_stb |
| rails_en | output | 1 | Global rail enable |
| restart_req | output | 1 | One-cycle restart request |
| live_stat | output | 5 | Real-time status |
| latched_stat | output | 5 | Sticky status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that tick is a single-cycle pulse. They also assume that every comparator flag is synchronous to clk, so that a flag seen at one edge is acted on at the next. The stimulus drives every flag, tick and the clear strobe one time unit after a rising edge. It never holds tick for two cycles in a row. It changes the masks only while the rails are running and no fault is pending. The tick-counting assertions therefore see clean, single edges.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   localparam int STAT_W  = 5;
   localparam int B_CYC   = 0;
   localparam int B_HOC   = 1;
   localparam int B_UV    = 2;
   localparam int B_WARN  = 3;
   localparam int B_THERM = 4;

   typedef enum logic {
      ST_RUN = 1'b0,
      ST_OFF = 1'b1
   } pfs_state_e;
endpackage

// File: rtl/pfs_fault_detect.sv
module pfs_fault_detect import pfs_pkg::*; #(
   parameter int N_RAILS = 4
) (
   input  logic [N_RAILS-1:0] cyc_lim_oc,
   input  logic [N_RAILS-1:0] hard_oc,
   input  logic [N_RAILS-1:0] uv,
   input  logic               temp_warn,
   input  logic               temp_shut,
   input  logic [STAT_W-1:0]  irq_mask,
   output logic [STAT_W-1:0]  live_stat,
   output logic               uv_shut,
   output logic               oc_shut,
   output logic               th_shut
);
   if (N_RAILS < 1) begin : g_bad_rails
      $error("pfs_fault_detect: N_RAILS must be at least 1");
   end

   // OR chains across the rails
   logic [N_RAILS:0] cyc_acc, hoc_acc, uv_acc;
   assign cyc_acc[0] = 1'b0;
   assign hoc_acc[0] = 1'b0;
   assign uv_acc[0]  = 1'b0;

   for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
      assign cyc_acc[g+1] = cyc_acc[g] | cyc_lim_oc[g];
      assign hoc_acc[g+1] = hoc_acc[g] | hard_oc[g];
      assign uv_acc[g+1]  = uv_acc[g]  | uv[g];
   end

   always_comb begin
      live_stat          = '0;
      live_stat[B_CYC]   = cyc_acc[N_RAILS];
      live_stat[B_HOC]   = hoc_acc[N_RAILS];
      live_stat[B_UV]    = uv_acc[N_RAILS];
      live_stat[B_WARN]  = temp_warn;
      live_stat[B_THERM] = temp_shut;
   end

   // Hard overcurrent ignores its mask; UV and thermal masks also gate shutdown
   assign oc_shut = hoc_acc[N_RAILS];
   assign uv_shut = uv_acc[N_RAILS] & ~irq_mask[B_UV];
   assign th_shut = temp_shut & ~irq_mask[B_THERM];
endmodule

// File: rtl/pfs_restart_timer.sv
module pfs_restart_timer import pfs_pkg::*; #(
   parameter int UV_DLY = 100,
   parameter int OC_DLY = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic uv_shut,
   input  logic oc_shut,
   input  logic th_shut,
   output logic rails_en,
   output logic restart_req
);
   localparam int MAX_DLY = (UV_DLY > OC_DLY) ? UV_DLY : OC_DLY;
   localparam int CNT_W   = $clog2(MAX_DLY + 1);

   if (UV_DLY < 1 || OC_DLY < 1) begin : g_bad_dly
      $error("pfs_restart_timer: delays must be at least one tick");
   end

   pfs_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] need_long, need_short;
   logic             hold;

   assign hold = uv_shut | oc_shut | th_shut;

   always_comb begin
      need_long  = (uv_shut | th_shut) ? CNT_W'(UV_DLY) : '0;
      need_short = oc_shut ? CNT_W'(OC_DLY) : '0;
      need       = (need_long > need_short) ? need_long : need_short;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_RUN;
         cnt         <= '0;
         restart_req <= 1'b0;
      end else begin
         restart_req <= 1'b0;
         unique case (state)
            ST_RUN: begin
               if (hold) begin
                  state <= ST_OFF;
                  cnt   <= need;
               end
            end
            ST_OFF: begin
               if (hold) begin
                  if (need > cnt) cnt <= need;
               end else if (tick) begin
                  if (cnt <= CNT_W'(1)) begin
                     state       <= ST_RUN;
                     cnt         <= '0;
                     restart_req <= 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   assign rails_en = (state == ST_RUN);

   assert_restart_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !restart_req);
   assert_restart_from_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> $past(state == ST_OFF));
   assert_hold_blocks_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !restart_req);
   assert_off_has_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |-> (cnt != '0));
endmodule

// File: rtl/pfs_status_latch.sv
module pfs_status_latch import pfs_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] live_stat,
   input  logic [STAT_W-1:0] irq_mask,
   input  logic              clr_stb,
   input  logic [STAT_W-1:0] clr_bits,
   output logic [STAT_W-1:0] latched_stat,
   output logic              irq_n
);
   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      logic lat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      lat_q <= 1'b0;
         else if (live_stat[b])           lat_q <= 1'b1;
         else if (clr_stb && clr_bits[b]) lat_q <= 1'b0;
      end
      assign latched_stat[b] = lat_q;

      assert_live_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
         live_stat[b] |=> latched_stat[b]);
      assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (latched_stat[b] && !(clr_stb && clr_bits[b])) |=> latched_stat[b]);
   end

   assign irq_n = ~|(latched_stat & ~irq_mask);
endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq import pfs_pkg::*; #(
   parameter int N_RAILS = 4,
   parameter int UV_DLY  = 100,
   parameter int OC_DLY  = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [N_RAILS-1:0] cyc_lim_oc,
   input  logic [N_RAILS-1:0] hard_oc,
   input  logic [N_RAILS-1:0] uv,
   input  logic               temp_warn,
   input  logic               temp_shut,
   input  logic [STAT_W-1:0]  irq_mask,
   input  logic               clr_stb,
   input  logic [STAT_W-1:0]  clr_bits,
   output logic               rails_en,
   output logic               restart_req,
   output logic [STAT_W-1:0]  live_stat,
   output logic [STAT_W-1:0]  latched_stat,
   output logic               irq_n
);
   logic uv_shut, oc_shut, th_shut;

   pfs_fault_detect #(.N_RAILS(N_RAILS)) u_detect (
      .cyc_lim_oc (cyc_lim_oc),
      .hard_oc    (hard_oc),
      .uv         (uv),
      .temp_warn  (temp_warn),
      .temp_shut  (temp_shut),
      .irq_mask   (irq_mask),
      .live_stat  (live_stat),
      .uv_shut    (uv_shut),
      .oc_shut    (oc_shut),
      .th_shut    (th_shut)
   );

   pfs_restart_timer #(.UV_DLY(UV_DLY), .OC_DLY(OC_DLY)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .uv_shut     (uv_shut),
      .oc_shut     (oc_shut),
      .th_shut     (th_shut),
      .rails_en    (rails_en),
      .restart_req (restart_req)
   );

   pfs_status_latch u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .live_stat    (live_stat),
      .irq_mask     (irq_mask),
      .clr_stb      (clr_stb),
      .clr_bits     (clr_bits),
      .latched_stat (latched_stat),
      .irq_n        (irq_n)
   );

   assert_hard_oc_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|hard_oc) |=> !rails_en);
   assert_uv_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((|uv) && !irq_mask[B_UV]) |=> !rails_en);
   assert_therm_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_shut && !irq_mask[B_THERM]) |=> !rails_en);
   assert_no_spurious_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rails_en && !(|hard_oc) && !((|uv) && !irq_mask[B_UV])
       && !(temp_shut && !irq_mask[B_THERM])) |=> rails_en);
endmodule

// File: tb/sim_pwr_fault_seq.sv
`timescale 1ns/1ps
module sim_pwr_fault_seq;
   localparam int NR = 4;
   localparam int UVD = 100;
   localparam int OCD = 14;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic [NR-1:0] cyc_lim_oc = '0, hard_oc = '0, uv = '0;
   logic temp_warn = 1'b0, temp_shut = 1'b0;
   logic [4:0] irq_mask = '0, clr_bits = '0;
   logic clr_stb = 1'b0;
   logic rails_en, restart_req, irq_n;
   logic [4:0] live_stat, latched_stat;

   int tests = 0, fails = 0, tick_cnt = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwr_fault_seq #(.N_RAILS(NR), .UV_DLY(UVD), .OC_DLY(OCD)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cyc_lim_oc(cyc_lim_oc),
      .hard_oc(hard_oc), .uv(uv), .temp_warn(temp_warn), .temp_shut(temp_shut),
      .irq_mask(irq_mask), .clr_stb(clr_stb), .clr_bits(clr_bits),
      .rails_en(rails_en), .restart_req(restart_req), .live_stat(live_stat),
      .latched_stat(latched_stat), .irq_n(irq_n));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // tick generator: one-cycle pulse every five clocks
   initial begin
      forever begin
         repeat (4) @(posedge clk);
         #1 tick = 1'b1;
         @(posedge clk);
         #1 tick = 1'b0;
      end
   end

   // monitor: pops expected restart delays as restarts appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (restart_req) begin
            if (exp_q.size() == 0) begin
               chk("R1 unexpected restart", 1, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk("R1/R2/R4/R5 restart tick count", tick_cnt, e);
               chk("R1 rails back with restart", rails_en, 1);
            end
            tick_cnt = 0;
         end
         if (tick && !rails_en && !(|uv) && !(|hard_oc) && !temp_shut)
            tick_cnt++;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_ticks(int n);
      repeat (n) @(negedge clk iff tick);
      @(posedge clk);
      #1;
   endtask

   task automatic clear_all();
      clr_stb = 1'b1;
      clr_bits = 5'h1f;
      cyc(1);
      clr_stb = 1'b0;
      clr_bits = '0;
   endtask

   task automatic wait_up();
      while (!rails_en) cyc(1);
      cyc(2);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R11 rails_en", rails_en, 1);
      chk("R11 restart_req", restart_req, 0);
      chk("R11 latched", latched_stat, 0);
      chk("R11 irq_n", irq_n, 1);

      // R7/R8/R10: cycle-limit only
      cyc_lim_oc = 4'b0100;
      #1 chk("R8 live cyc bit0", live_stat, 5'h01);
      cyc(3);
      chk("R7 rails stay on", rails_en, 1);
      chk("R9 latched bit0", latched_stat, 5'h01);
      chk("R10 irq low", irq_n, 0);
      cyc_lim_oc = '0;
      cyc(1);
      clear_all();
      chk("R9 cleared", latched_stat, 0);
      chk("R10 irq high", irq_n, 1);

      // R6: warning unmasked, then masked
      temp_warn = 1'b1;
      cyc(2);
      chk("R6 irq on warning", irq_n, 0);
      chk("R6 rails on", rails_en, 1);
      clr_stb = 1'b1; clr_bits = 5'h08;
      cyc(1);
      clr_stb = 1'b0; clr_bits = '0;
      chk("R9 live bit survives clear", latched_stat, 5'h08);
      irq_mask = 5'h08;
      #1 chk("R6 masked warning irq", irq_n, 1);
      chk("R8 live warn under mask", live_stat, 5'h08);
      temp_warn = 1'b0;
      cyc(1);
      clear_all();
      irq_mask = '0;

      // R1: undervoltage
      exp_q.push_back(UVD);
      uv = 4'b0001;
      cyc(1);
      uv = '0;
      chk("R1 rails off", rails_en, 0);
      wait_up();
      clear_all();

      // R2/R3: masked hard overcurrent still shuts down
      irq_mask = 5'h02;
      exp_q.push_back(OCD);
      hard_oc = 4'b1000;
      cyc(1);
      hard_oc = '0;
      chk("R2 rails off", rails_en, 0);
      cyc(1);
      chk("R3 irq silent", irq_n, 1);
      chk("R3 latched hoc", latched_stat, 5'h02);
      wait_up();
      clear_all();
      irq_mask = '0;

      // R4: short then long -> extended
      exp_q.push_back(5 + UVD);
      hard_oc = 4'b0010;
      cyc(1);
      hard_oc = '0;
      wait_ticks(5);
      uv = 4'b0010;
      cyc(1);
      uv = '0;
      wait_up();
      clear_all();

      // R4: long then short -> unchanged
      exp_q.push_back(UVD);
      uv = 4'b0100;
      cyc(1);
      uv = '0;
      wait_ticks(30);
      hard_oc = 4'b0001;
      cyc(1);
      hard_oc = '0;
      wait_up();
      clear_all();

      // R5: thermal held off until clear
      exp_q.push_back(UVD);
      temp_shut = 1'b1;
      cyc(1);
      wait_ticks(20);
      chk("R5 held off", rails_en, 0);
      temp_shut = 1'b0;
      wait_up();
      clear_all();

      // R5: masked thermal keeps rails on
      irq_mask = 5'h10;
      temp_shut = 1'b1;
      cyc(50);
      chk("R5 masked thermal rails on", rails_en, 1);
      chk("R8 live therm", live_stat, 5'h10);
      temp_shut = 1'b0;
      cyc(1);
      clear_all();

      // R1: masked undervoltage keeps rails on
      irq_mask = 5'h04;
      uv = 4'b1000;
      cyc(20);
      chk("R1 masked uv rails on", rails_en, 1);
      uv = '0;
      cyc(1);
      clear_all();
      irq_mask = '0;

      cyc(200);
      chk("R1 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule